// File: doc/BRIEF.md
# Queued Hardware Semaphore Bank

This block holds a set of hardware semaphores that several processor cores share to guard critical sections. Each core has its own request port. A request names a semaphore and an operation: a polled query, a queued query or a release. Every request gets a registered response code one cycle later. A polled query either takes a free semaphore or reports busy, and the core is expected to try again. A queued query on a busy semaphore puts the core into that semaphore's first-in first-out wait list. When ownership reaches the core, its interrupt line pulses.

Requests that arrive in the same cycle are handled one at a time, in ascending core order, against the state that earlier cores in that cycle have already changed. A test-and-take is therefore atomic: a free semaphore goes to exactly one core. A read port returns the current owner of any semaphore, together with a valid flag.

Top module: `sem_bank`

## Requirements
- R1: After synchronous reset every semaphore is free, all wait lists are empty, and `rsp_valid`, `rsp_code` and `irq` are all zero. A read of any semaphore returns `rd_valid` = 0.
- R2: The operation codes are 0 = polled query, 1 = queued query, 2 = release, and 3 = reserved. The response codes are 0 = done/granted, 1 = busy, 2 = queued, 3 = error. A request made in cycle n is answered in cycle n+1. A polled query on a free semaphore returns 0 and makes the core the owner. On a busy semaphore it returns 1 and changes nothing. The reserved code returns 3 and changes nothing.
- R3: A queued query on a busy semaphore returns 2 and appends the core to the wait list. A queued query on a free semaphore returns 0, and the core's `irq` pulses in the same cycle as that response.
- R4: Waiting cores are granted strictly in the order in which they were queued.
- R5: Requests from several cores in one cycle are applied in ascending core-ID order. Each request sees the effects of the lower-numbered cores. At most one core ever receives a given free semaphore.
- R6: A release from a core that is not the current owner returns 3 and leaves the owner and the wait list unchanged.
- R7: A release by the owner returns 0. If the wait list is not empty, its head becomes owner at the same register update and that core's `irq` is high for exactly one cycle. If the wait list is empty, the semaphore becomes free.
- R8: A query of either kind from a core that already owns or is waiting on that semaphore returns 3 and adds no entry.
- R9: No wait list ever holds more than NUM_CORES-1 entries, and the owner never appears in its own wait list.
- R10: Driving `rd_sem` in cycle n gives, in cycle n+1, `rd_valid` and `rd_owner` for that semaphore's owner as it stood at the start of cycle n. `rd_owner` reads 0 when the semaphore is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | One request strobe per core |
| req_op | input | 2*NUM_CORES | Operation code per core, 2 bits each |
| req_sem | input | SEM_W*NUM_CORES | Semaphore index per core |
| rsp_valid | output | NUM_CORES | Response strobe per core |
| rsp_code | output | 2*NUM_CORES | Response code per core, 2 bits each |
| irq | output | NUM_CORES | One-cycle grant pulse per core |
| rd_sem | input | SEM_W | Semaphore selected for owner read |
| rd_valid | output | 1 | Selected semaphore is owned |
| rd_owner | output | CORE_W | Owner ID of the selected semaphore |

## Verification
The hardest state to reach from the ports is a full wait list followed by a chain of hand-offs. The stimulus gets there with queued queries from every non-owning core, two of them in the same cycle so that ascending-ID order decides their positions. It then re-requests from both the owner and a waiting core to show that no duplicate entry is added. Finally it releases in turn and watches each interrupt pulse and owner read-back arrive in FIFO order. A further cycle mixes polled and queued queries from three cores on one free semaphore. Another pairs a release with a polled query in one cycle, to show the serial same-cycle resolution.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OP_POLL    = 2'd0,
    OP_QUEUE   = 2'd1,
    OP_RELEASE = 2'd2,
    OP_RSVD    = 2'd3
  } sem_op_t;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_BUSY   = 2'd1,
    RSP_QUEUED = 2'd2,
    RSP_ERR    = 2'd3
  } sem_rsp_t;
endpackage

// File: rtl/sem_slot.sv
module sem_slot
  import sem_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int QD = NUM_CORES - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CORES-1:0]   hit,
  input  logic [2*NUM_CORES-1:0] op_bus,
  output logic [NUM_CORES-1:0]   rsp_v,
  output logic [2*NUM_CORES-1:0] rsp_c,
  output logic [NUM_CORES-1:0]   irq_o,
  output logic                   own_v,
  output logic [CORE_W-1:0]      own_id
);
  logic                 own_v_r, n_ov;
  logic [CORE_W-1:0]    own_r, n_own;
  logic [CORE_W-1:0]    q_r [QD];
  logic [CORE_W-1:0]    n_q [QD];
  logic [CORE_W-1:0]    cnt_r, n_cnt;
  logic [NUM_CORES-1:0] wait_r, n_wait;
  logic [NUM_CORES-1:0] n_rv, n_irq, rv_r, irq_r;
  logic [2*NUM_CORES-1:0] n_rc, rc_r;

  // Serial walk over the cores in ascending ID; each step sees prior steps.
  always_comb begin
    n_ov   = own_v_r;
    n_own  = own_r;
    n_q    = q_r;
    n_cnt  = cnt_r;
    n_wait = wait_r;
    n_rv   = '0;
    n_rc   = '0;
    n_irq  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (hit[c]) begin
        n_rv[c] = 1'b1;
        unique case (sem_op_t'(op_bus[2*c +: 2]))
          OP_POLL, OP_QUEUE: begin
            if ((n_ov && n_own == CORE_W'(c)) || n_wait[c]) begin
              n_rc[2*c +: 2] = RSP_ERR;
            end else if (!n_ov) begin
              n_ov  = 1'b1;
              n_own = CORE_W'(c);
              n_rc[2*c +: 2] = RSP_OK;
              if (sem_op_t'(op_bus[2*c +: 2]) == OP_QUEUE) n_irq[c] = 1'b1;
            end else if (sem_op_t'(op_bus[2*c +: 2]) == OP_QUEUE) begin
              n_q[n_cnt] = CORE_W'(c);
              n_cnt      = n_cnt + CORE_W'(1);
              n_wait[c]  = 1'b1;
              n_rc[2*c +: 2] = RSP_QUEUED;
            end else begin
              n_rc[2*c +: 2] = RSP_BUSY;
            end
          end
          OP_RELEASE: begin
            if (n_ov && n_own == CORE_W'(c)) begin
              n_rc[2*c +: 2] = RSP_OK;
              if (n_cnt != '0) begin
                n_own = n_q[0];
                n_wait[n_q[0]] = 1'b0;
                n_irq[n_q[0]]  = 1'b1;
                for (int j = 0; j < QD - 1; j++) n_q[j] = n_q[j+1];
                n_cnt = n_cnt - CORE_W'(1);
              end else begin
                n_ov = 1'b0;
              end
            end else begin
              n_rc[2*c +: 2] = RSP_ERR;
            end
          end
          default: n_rc[2*c +: 2] = RSP_ERR;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v_r <= 1'b0;
      own_r   <= '0;
      cnt_r   <= '0;
      wait_r  <= '0;
      rv_r    <= '0;
      rc_r    <= '0;
      irq_r   <= '0;
    end else begin
      own_v_r <= n_ov;
      own_r   <= n_own;
      cnt_r   <= n_cnt;
      wait_r  <= n_wait;
      rv_r    <= n_rv;
      rc_r    <= n_rc;
      irq_r   <= n_irq;
    end
  end

  // Wait-list storage has no reset; only entries below cnt_r are meaningful.
  always_ff @(posedge clk) begin
    q_r <= n_q;
  end

  assign rsp_v  = rv_r;
  assign rsp_c  = rc_r;
  assign irq_o  = irq_r;
  assign own_v  = own_v_r;
  assign own_id = own_r;

  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_r <= CORE_W'(QD));
  assert_owner_not_waiting_R9: assert property (@(posedge clk) disable iff (rst)
    own_v_r |-> !wait_r[own_r]);
  assert_free_means_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !own_v_r |-> (cnt_r == '0 && wait_r == '0));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    assert_irq_to_owner_R3: assert property (@(posedge clk) disable iff (rst)
      irq_r[g] |-> (own_v_r && own_r == CORE_W'(g)));
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      irq_r[g] |=> !irq_r[g]);
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SEMS  = 8,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int SEM_W  = $clog2(NUM_SEMS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CORES-1:0]       req_valid,
  input  logic [2*NUM_CORES-1:0]     req_op,
  input  logic [SEM_W*NUM_CORES-1:0] req_sem,
  output logic [NUM_CORES-1:0]       rsp_valid,
  output logic [2*NUM_CORES-1:0]     rsp_code,
  output logic [NUM_CORES-1:0]       irq,
  input  logic [SEM_W-1:0]           rd_sem,
  output logic                       rd_valid,
  output logic [CORE_W-1:0]          rd_owner
);
  logic [NUM_CORES-1:0]   s_rv  [NUM_SEMS];
  logic [2*NUM_CORES-1:0] s_rc  [NUM_SEMS];
  logic [NUM_CORES-1:0]   s_irq [NUM_SEMS];
  logic                   s_ov  [NUM_SEMS];
  logic [CORE_W-1:0]      s_own [NUM_SEMS];

  for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
    logic [NUM_CORES-1:0] hit;
    always_comb begin
      for (int c = 0; c < NUM_CORES; c++)
        hit[c] = req_valid[c] && (req_sem[c*SEM_W +: SEM_W] == SEM_W'(s));
    end
    sem_slot #(.NUM_CORES(NUM_CORES)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit),
      .op_bus (req_op),
      .rsp_v  (s_rv[s]),
      .rsp_c  (s_rc[s]),
      .irq_o  (s_irq[s]),
      .own_v  (s_ov[s]),
      .own_id (s_own[s])
    );
  end

  // Each core addresses one semaphore per cycle, so per-slot outputs are disjoint.
  always_comb begin
    rsp_valid = '0;
    rsp_code  = '0;
    irq       = '0;
    for (int s = 0; s < NUM_SEMS; s++) begin
      rsp_valid = rsp_valid | s_rv[s];
      rsp_code  = rsp_code  | s_rc[s];
      irq       = irq       | s_irq[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_owner <= '0;
    end else if (int'(rd_sem) < NUM_SEMS) begin
      rd_valid <= s_ov[rd_sem];
      rd_owner <= s_ov[rd_sem] ? s_own[rd_sem] : '0;
    end else begin
      rd_valid <= 1'b0;
      rd_owner <= '0;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_rsp_chk
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[c] |-> $past(req_valid[c]));
    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (rst)
      !req_valid[c] |=> !rsp_valid[c]);
  end
endmodule

// File: tb/test_sem_bank.sv
module test_sem_bank;
  localparam int NC = 4;
  localparam int NS = 8;
  localparam int CW = $clog2(NC);
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    req_valid = '0;
  logic [2*NC-1:0]  req_op = '0;
  logic [SW*NC-1:0] req_sem = '0;
  logic [NC-1:0]    rsp_valid;
  logic [2*NC-1:0]  rsp_code;
  logic [NC-1:0]    irq;
  logic [SW-1:0]    rd_sem = '0;
  logic             rd_valid;
  logic [CW-1:0]    rd_owner;

  sem_bank #(.NUM_CORES(NC), .NUM_SEMS(NS)) i_sem_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_sem(req_sem), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .irq(irq), .rd_sem(rd_sem), .rd_valid(rd_valid), .rd_owner(rd_owner)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [NC-1:0]   rv;
    logic [2*NC-1:0] rc;
    logic [NC-1:0]   ir;
    logic            chk_rd;
    logic            rdv;
    logic [CW-1:0]   rdo;
    string           tag;
  } item_t;

  item_t exp_q [$];
  item_t cur;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic clear_cur();
    cur.rv = '0; cur.rc = '0; cur.ir = '0;
    cur.chk_rd = 1'b0; cur.rdv = 1'b0; cur.rdo = '0; cur.tag = "";
  endtask

  task automatic req(input int core, input logic [1:0] op, input int sem, input logic [1:0] code);
    req_valid[core] = 1'b1;
    req_op[2*core +: 2] = op;
    req_sem[core*SW +: SW] = SW'(sem);
    cur.rv[core] = 1'b1;
    cur.rc[2*core +: 2] = code;
  endtask

  task automatic exp_irq(input int core);
    cur.ir[core] = 1'b1;
  endtask

  task automatic read_own(input int sem, input logic v, input int own);
    rd_sem = SW'(sem);
    cur.chk_rd = 1'b1; cur.rdv = v; cur.rdo = CW'(own);
  endtask

  // Driver: push this cycle's expectation, advance one cycle, clear the drive.
  task automatic tick(input string tag);
    cur.tag = tag;
    exp_q.push_back(cur);
    @(negedge clk);
    req_valid = '0; req_op = '0; req_sem = '0; rd_sem = '0;
    clear_cur();
  endtask

  // Monitor: compare results after each active edge.
  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      item_t it;
      #2;
      it = exp_q.pop_front();
      checks++;
      if (rsp_valid !== it.rv || rsp_code !== it.rc || irq !== it.ir) begin
        errors++;
        $display("FAIL %s: rsp_valid=%b rsp_code=%b irq=%b expected %b %b %b",
                 it.tag, rsp_valid, rsp_code, irq, it.rv, it.rc, it.ir);
      end
      if (it.chk_rd) begin
        checks++;
        if (rd_valid !== it.rdv || rd_owner !== it.rdo) begin
          errors++;
          $display("FAIL %s: rd_valid=%b rd_owner=%0d expected %b %0d",
                   it.tag, rd_valid, rd_owner, it.rdv, it.rdo);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_cur();
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (rsp_valid !== '0 || rsp_code !== '0 || irq !== '0 || rd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: rsp_valid=%b rsp_code=%b irq=%b rd_valid=%b expected all zero",
               rsp_valid, rsp_code, irq, rd_valid);
    end
    @(negedge clk);
    rst = 1'b0;

    read_own(0, 1'b0, 0);                       tick("R1 owner read after reset");
    req(0, 2'd0, 1, 2'd0);                      tick("R2 poll on free grants");
    req(1, 2'd0, 1, 2'd1); read_own(1, 1'b1, 0); tick("R2 R10 poll on busy");
    req(2, 2'd1, 1, 2'd2); req(1, 2'd1, 1, 2'd2); tick("R3 R5 two queued same cycle");
    req(3, 2'd1, 1, 2'd2);                      tick("R3 R9 queue filled");
    req(1, 2'd1, 1, 2'd3); req(0, 2'd0, 1, 2'd3); tick("R8 duplicate requests");
    req(2, 2'd2, 1, 2'd3); read_own(1, 1'b1, 0); tick("R6 release by non-owner");
    req(0, 2'd2, 1, 2'd0); exp_irq(1);          tick("R4 R7 hand-off to first waiter");
    read_own(1, 1'b1, 1);                       tick("R7 R10 irq pulse ends, new owner");
    req(1, 2'd2, 1, 2'd0); exp_irq(2);          tick("R4 hand-off to second waiter");
    req(2, 2'd2, 1, 2'd0); exp_irq(3);          tick("R4 R8 hand-off to third waiter");
    req(3, 2'd2, 1, 2'd0);                      tick("R7 release with empty list");
    read_own(1, 1'b0, 0);                       tick("R7 semaphore free");
    req(3, 2'd0, 2, 2'd1); req(1, 2'd0, 2, 2'd0); req(2, 2'd1, 2, 2'd2);
                                                tick("R5 mixed contention lowest ID wins");
    req(1, 2'd2, 2, 2'd0); exp_irq(2); read_own(2, 1'b1, 1); tick("R4 R5 queued waiter served");
    req(2, 2'd2, 2, 2'd0); read_own(2, 1'b1, 2); tick("R7 release after hand-off");
    req(0, 2'd1, 3, 2'd0); exp_irq(0);          tick("R3 queued query on free");
    req(0, 2'd2, 3, 2'd0); req(1, 2'd0, 3, 2'd0); tick("R5 release then poll same cycle");
    req(0, 2'd0, 4, 2'd0); req(1, 2'd0, 5, 2'd0); req(2, 2'd3, 6, 2'd3); read_own(3, 1'b1, 1);
                                                tick("R2 R5 independent sems and reserved op");
    req(2, 2'd0, 6, 2'd0); read_own(4, 1'b1, 0); tick("R2 reserved op left sem free");
    read_own(6, 1'b1, 2);                       tick("R10 owner read sem6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule